// File: doc/BRIEF.md
# Line-Mode PRBS Transmit Source

This block is the transmit-side test pattern source for one channel of a multi-rate line interface. When it is enabled, it sends an unframed pseudo-random bit sequence toward the line at one bit per transmit clock. The sequence length follows the selected line mode. The short sequence (period 2^15-1) serves the DS3 and STS-1 rates. The long sequence (period 2^23-1) serves the E3 rate. While the pattern is running, the data offered on the system-side positive and negative rails is discarded. The output is forced to single-rail form: the pattern goes out on the positive rail and the negative rail stays low.

When it is disabled, the block passes the system rails through to the line rails behind one register stage. The same single enable bit also controls the receive-side checker of the channel, so that both sides switch on and off together. Each pattern generator is a Fibonacci shift register. It is reloaded with all ones whenever its pattern is not the one being sent. A sequence therefore always begins from the same known point, and the register can never sit at zero.

Top module: `prbs_tx_gen`

## Requirements
- R1: With `mode_e3`=0 and `prbs_on`=1, the sent bit is the MSB of a 15-stage register. On each clock the register shifts left and takes bit14 XOR bit13 into bit 0 (polynomial x^15+x^14+1). The sequence repeats every 32767 bits.
- R2: With `mode_e3`=1 and `prbs_on`=1, the sent bit is the MSB of a 23-stage register. On each clock the register shifts left and takes bit22 XOR bit17 into bit 0 (polynomial x^23+x^18+1).
- R3: A pattern register is all ones while its pattern is not being sent, and it is never all zeros. The first bits after enabling are therefore the MSBs of the all-ones seed.
- R4: While `prbs_on`=1, `line_neg` is 0 one clock later, whatever the value of `sys_neg`.
- R5: While `prbs_on`=0, `line_pos` and `line_neg` equal `sys_pos` and `sys_neg` from the previous clock edge.
- R6: While `prbs_on`=1, the values of `sys_pos` and `sys_neg` have no effect on `line_pos`.
- R7: A change of `mode_e3` while enabled restarts the newly chosen pattern from the all-ones seed at that same edge.
- R8: While `rst_n`=0, both line rails are 0 and both pattern registers hold the all-ones seed.
- R9: One pattern bit is sent per clock, and it appears on `line_pos` one clock after the edge that sampled the enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit data-rate clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prbs_on | input | 1 | Pattern enable (shared with the receive checker) |
| mode_e3 | input | 1 | 1 selects the long (E3) pattern, 0 the short (DS3/STS-1) pattern |
| sys_pos | input | 1 | System-side positive rail data |
| sys_neg | input | 1 | System-side negative rail data |
| line_pos | output | 1 | Positive rail toward the line |
| line_neg | output | 1 | Negative rail toward the line |

## Verification
The bench builds the block with its default lengths and taps, 15/14 and 23/18. At those values the whole short period of 32767 bits can be swept bit by bit. This sweep confirms both the feedback arithmetic and the exact repeat point. The long pattern is compared against a bench-side arithmetic model over twenty thousand bits. The bench also covers all four system rail combinations in both enable states, as well as mode switches in the middle of a run.

// File: rtl/prbs_tx_pkg.sv
package prbs_tx_pkg;

   // Index of each pattern generator inside the selector.
   typedef enum logic {
      SEQ_SHORT = 1'b0,
      SEQ_LONG  = 1'b1
   } seq_sel_e;

   localparam int unsigned SEQ_COUNT = 2;

   // Shared legality rule for a two-tap Fibonacci register.
   function automatic bit taps_legal(input int unsigned len, input int unsigned tap);
      return (len >= 3) && (tap >= 1) && (tap < len);
   endfunction

endpackage

// File: rtl/prbs_lfsr_core.sv
module prbs_lfsr_core
   import prbs_tx_pkg::*;
#(
   parameter int unsigned STAGES = 15,
   parameter int unsigned TAP    = 14
) (
   input  logic clk,
   input  logic rst_n,
   input  logic reload,
   output logic seq_bit
);

   localparam logic [STAGES-1:0] SEED = {STAGES{1'b1}};

   if (!taps_legal(STAGES, TAP)) begin : g_bad_taps
      $error("prbs_lfsr_core: TAP must lie in 1..STAGES-1 and STAGES must be at least 3");
   end

   logic [STAGES-1:0] shreg;
   logic              fb;

   assign fb      = shreg[STAGES-1] ^ shreg[TAP-1];
   assign seq_bit = shreg[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= SEED;
      end else if (reload) begin
         shreg <= SEED;
      end else begin
         shreg <= {shreg[STAGES-2:0], fb};
      end
   end

   // R3: the register never reaches the lock-up state
   p_never_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      shreg != '0);

   // R7: an idle or deselected generator is back at the seed
   p_reload_seed_r7: assert property (@(posedge clk) disable iff (!rst_n)
      reload |=> (shreg == SEED));

   // R1: a running generator moves its bits one place toward the MSB
   p_shift_msb_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !reload |=> (shreg[STAGES-1] == $past(shreg[STAGES-2])));

endmodule

// File: rtl/prbs_seq_select.sv
module prbs_seq_select
   import prbs_tx_pkg::*;
#(
   parameter int unsigned SHORT_STAGES = 15,
   parameter int unsigned SHORT_TAP    = 14,
   parameter int unsigned LONG_STAGES  = 23,
   parameter int unsigned LONG_TAP     = 18
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic use_long,
   output logic seq_bit
);

   if (LONG_STAGES <= SHORT_STAGES) begin : g_bad_order
      $error("prbs_seq_select: the long pattern needs more stages than the short one");
   end

   logic [SEQ_COUNT-1:0] gen_bit;
   logic [SEQ_COUNT-1:0] gen_live;

   for (genvar g = 0; g < SEQ_COUNT; g++) begin : g_seq
      // A generator runs only while enabled and selected; otherwise it reloads.
      assign gen_live[g] = run && (use_long == (g == int'(SEQ_LONG)));

      if (g == int'(SEQ_LONG)) begin : g_long
         prbs_lfsr_core #(.STAGES(LONG_STAGES), .TAP(LONG_TAP)) u_core (
            .clk     (clk),
            .rst_n   (rst_n),
            .reload  (!gen_live[g]),
            .seq_bit (gen_bit[g])
         );
      end else begin : g_short
         prbs_lfsr_core #(.STAGES(SHORT_STAGES), .TAP(SHORT_TAP)) u_core (
            .clk     (clk),
            .rst_n   (rst_n),
            .reload  (!gen_live[g]),
            .seq_bit (gen_bit[g])
         );
      end
   end

   assign seq_bit = use_long ? gen_bit[SEQ_LONG] : gen_bit[SEQ_SHORT];

   // R7: a mode switch while enabled starts the new pattern at a seed bit
   p_switch_seed_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && (use_long != $past(use_long))) |-> (seq_bit == 1'b1));

endmodule

// File: rtl/prbs_rail_out.sv
module prbs_rail_out (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic seq_bit,
   input  logic sys_pos,
   input  logic sys_neg,
   output logic line_pos,
   output logic line_neg
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_pos <= 1'b0;
         line_neg <= 1'b0;
      end else if (run) begin
         line_pos <= seq_bit;
         line_neg <= 1'b0;
      end else begin
         line_pos <= sys_pos;
         line_neg <= sys_neg;
      end
   end

   // R4: single-rail form is forced while the pattern runs
   p_neg_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      run |=> (line_neg == 1'b0));

   // R5: the system rails pass through one stage late while disabled
   p_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> ((line_pos == $past(sys_pos)) && (line_neg == $past(sys_neg))));

   // R6: while enabled the positive rail follows the pattern, not the system
   p_pattern_r6: assert property (@(posedge clk) disable iff (!rst_n)
      run |=> (line_pos == $past(seq_bit)));

   // R8: the rails are low during reset
   always_comb begin
      if (!rst_n) begin
         p_reset_low_r8: assert (line_pos == 1'b0 && line_neg == 1'b0);
      end
   end

endmodule

// File: rtl/prbs_tx_gen.sv
module prbs_tx_gen
   import prbs_tx_pkg::*;
#(
   parameter int unsigned SHORT_STAGES = 15,
   parameter int unsigned SHORT_TAP    = 14,
   parameter int unsigned LONG_STAGES  = 23,
   parameter int unsigned LONG_TAP     = 18
) (
   input  logic clk,
   input  logic rst_n,
   input  logic prbs_on,
   input  logic mode_e3,
   input  logic sys_pos,
   input  logic sys_neg,
   output logic line_pos,
   output logic line_neg
);

   logic seq_bit;

   prbs_seq_select #(
      .SHORT_STAGES (SHORT_STAGES),
      .SHORT_TAP    (SHORT_TAP),
      .LONG_STAGES  (LONG_STAGES),
      .LONG_TAP     (LONG_TAP)
   ) u_sel (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (prbs_on),
      .use_long (mode_e3),
      .seq_bit  (seq_bit)
   );

   prbs_rail_out u_rail (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (prbs_on),
      .seq_bit  (seq_bit),
      .sys_pos  (sys_pos),
      .sys_neg  (sys_neg),
      .line_pos (line_pos),
      .line_neg (line_neg)
   );

   // R9: the first enabled edge sends the seed MSB on the next cycle
   p_first_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (prbs_on && !$past(prbs_on)) |=> (line_pos == 1'b1));

endmodule

// File: tb/prbs_tx_gen_bench.sv
`timescale 1ns/1ps
module prbs_tx_gen_bench;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic prbs_on = 1'b0;
   logic mode_e3 = 1'b0;
   logic sys_pos = 1'b0;
   logic sys_neg = 1'b0;
   logic line_pos;
   logic line_neg;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   logic [14:0] m_short = '1;
   logic [22:0] m_long  = '1;
   logic exp_pos;
   logic exp_neg;

   logic first_bits [0:63];

   always #5 clk = ~clk;

   prbs_tx_gen u_prbs_tx_gen (
      .clk      (clk),
      .rst_n    (rst_n),
      .prbs_on  (prbs_on),
      .mode_e3  (mode_e3),
      .sys_pos  (sys_pos),
      .sys_neg  (sys_neg),
      .line_pos (line_pos),
      .line_neg (line_neg)
   );

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   // Drives at a falling edge, applies one rising edge, checks at the next falling edge.
   task automatic tick(input logic en, input logic e3, input logic p, input logic n,
                       input string req);
      logic fb;
      prbs_on = en; mode_e3 = e3; sys_pos = p; sys_neg = n;
      if (!en) begin
         exp_pos = p; exp_neg = n;
         m_short = '1; m_long = '1;
      end else if (!e3) begin
         exp_pos = m_short[14]; exp_neg = 1'b0;
         fb = m_short[14] ^ m_short[13];
         m_short = {m_short[13:0], fb};
         m_long = '1;
      end else begin
         exp_pos = m_long[22]; exp_neg = 1'b0;
         fb = m_long[22] ^ m_long[17];
         m_long = {m_long[21:0], fb};
         m_short = '1;
      end
      @(posedge clk);
      @(negedge clk);
      check(req, line_pos, exp_pos);
      check(req, line_neg, exp_neg);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      // R8: reset state
      @(negedge clk);
      sys_pos = 1'b1; sys_neg = 1'b1;
      @(negedge clk);
      check("R8 pos", line_pos, 1'b0);
      check("R8 neg", line_neg, 1'b0);
      rst_n = 1'b1;

      // R5: pass-through of every rail combination
      for (int i = 0; i < 8; i++) tick(1'b0, i[2], i[0], i[1], "R5");

      // R3, R9: first bits after enabling come from the all-ones seed
      for (int i = 0; i < 15; i++) begin
         tick(1'b1, 1'b0, 1'b1, 1'b1, "R3");
         check("R3 seed", line_pos, 1'b1);
      end

      // R1, R4, R6: full short period with changing system rails
      m_short = '1;
      tick(1'b0, 1'b0, 1'b0, 1'b0, "R5");
      for (int i = 0; i < 32767 + 64; i++) begin
         tick(1'b1, 1'b0, i[0] ^ i[3], i[1], "R1/R4/R6");
         if (i < 64) first_bits[i] = line_pos;
         else if (i >= 32767) check("R1 period", line_pos, first_bits[i - 32767]);
      end

      // R7: switch to the long pattern mid-run, and back
      tick(1'b1, 1'b1, 1'b0, 1'b1, "R7");
      check("R7 seed", line_pos, 1'b1);
      for (int i = 0; i < 40; i++) tick(1'b1, 1'b1, i[1], i[0], "R7");
      tick(1'b1, 1'b0, 1'b1, 1'b0, "R7");
      check("R7 back", line_pos, 1'b1);
      for (int i = 0; i < 40; i++) tick(1'b1, 1'b0, i[2], 1'b1, "R7");

      // R2: long pattern against the arithmetic model
      tick(1'b0, 1'b1, 1'b1, 1'b0, "R5");
      for (int i = 0; i < 20000; i++) tick(1'b1, 1'b1, i[2] ^ i[0], i[4], "R2/R4/R6");

      // R5 again after disabling mid-sequence
      for (int i = 0; i < 4; i++) tick(1'b0, 1'b1, i[0], i[1], "R5");

      // R8: reset in the middle of a run reseeds
      for (int i = 0; i < 30; i++) tick(1'b1, 1'b0, 1'b0, 1'b0, "R1");
      @(negedge clk);
      rst_n = 1'b0;
      #2;
      check("R8 async pos", line_pos, 1'b0);
      check("R8 async neg", line_neg, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      m_short = '1; m_long = '1;
      for (int i = 0; i < 20; i++) tick(1'b1, 1'b0, 1'b1, 1'b1, "R8/R3");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule